// File: doc/BRIEF.md
# Ring Frame Transmit Sequencer

This block turns a frame body, offered as a byte stream from the frame-control byte through the last information byte, into a complete token-ring frame on a symbol-pair output. The output carries one symbol pair per clock: either a data byte or one of four control codes. Between frames the line carries idle pairs. When a body is offered, the block sends a programmable run of idle-pair preamble, then the start delimiter, then the body. It replaces the source-address field with the station's own address and appends a 32-bit check sequence, each unless its transparency pin is set. The frame closes with the two-pair end sequence.

The length bit of the frame-control byte chooses two-byte or six-byte address fields. A body that ends, or stalls, before its source address is complete cannot be finished. The block then closes what it has already sent and follows it with an internally built Void frame, so downstream stations still see valid traffic.

The request side is valid/ready. `req_ready` is high only while the block is taking body bytes, and a byte moves on a clock edge where both `req_valid` and `req_ready` are high. The line cannot pause once a frame has started, so the requester must present a byte in every cycle that `req_ready` is high. A cycle with `req_ready` high and `req_valid` low counts as a stall and aborts the frame. `pre_len`, `sa_pass`, `fcs_pass`, `stn_short` and `stn_long` are plain control inputs and must be held steady while a frame is in progress.

Top module: `ring_frame_tx`

## Requirements
- R1: After reset the output is an idle pair (`sym_ctrl`=1, `sym_data`=0x00) and `req_ready` is 0.
- R2: The preamble length P is `pre_len` clamped to the range 8..40. From idle, if `req_valid` is first seen high at a clock edge, the next P+1 output symbols are idle pairs and the following one is the start delimiter (`sym_ctrl`=1, `sym_data`=0x01).
- R3: The symbol after the start delimiter is the frame-control byte, unchanged (`sym_ctrl`=0).
- R4: Bit 6 (value 0x40) of the frame-control byte selects the address length L: L=6 when the bit is set, L=2 when it is clear. Body byte 0 is frame control, bytes 1..L are the destination, and bytes L+1..2L are the source.
- R5: With `sa_pass`=0, source bytes are replaced by the station address, most significant byte first: `stn_long` when L=6, `stn_short` when L=2. With `sa_pass`=1 the input bytes are sent as they are.
- R6: With `fcs_pass`=0, four data bytes follow the last body byte. Their value is a CRC-32 over the transmitted body, including any substituted address: polynomial 0x04C11DB7, register preset to all ones, each byte fed MSB first, result inverted, sent most significant byte first.
- R7: With `fcs_pass`=1, no check bytes are added. The body passes through unchanged and the end sequence follows its last byte at once.
- R8: Every frame ends with the pair TR (`sym_ctrl`=1, 0x02) and then RR (`sym_ctrl`=1, 0x03), followed by idle pairs.
- R9: If `req_last` comes with a body byte whose index is below 2L, that byte is sent, then TR, RR and P idle pairs. A Void frame follows: start delimiter, frame control 0x00 (L=2) or 0x40 (L=6, taken from the aborted frame), L zero bytes, L station-address bytes, the R6 check sequence, TR, RR. A body ending exactly at index 2L is a valid frame.
- R10: A stall (`req_ready`=1 while `req_valid`=0) sends TR in the next symbol, then RR, then the R9 Void frame. The Void frame always uses the station address and check sequence, whatever `sa_pass` and `fcs_pass` say. A stall before frame control is taken gives a short Void frame.
- R11: `req_ready` is high only while body bytes of a requested frame are being taken. It is low in idle, preamble, delimiter, check sequence, end sequence and the whole Void frame, and low in the cycle after the byte marked `req_last` is taken.
- R12: When a new body is already waiting, exactly P+1 idle pairs separate the RR of one frame from the next start delimiter. Exactly P separate an aborted frame's RR from its Void frame's delimiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Body byte valid |
| req_data | input | 8 | Body byte |
| req_last | input | 1 | Marks the last body byte |
| req_ready | output | 1 | Block takes a body byte this cycle |
| pre_len | input | 6 | Requested preamble length in idle pairs (clamped 8..40) |
| sa_pass | input | 1 | Send the source address from the input stream |
| fcs_pass | input | 1 | Send the input's last four bytes as the check sequence |
| stn_short | input | 16 | Station two-byte address |
| stn_long | input | 48 | Station six-byte address |
| sym_data | output | 8 | Data byte or control code |
| sym_ctrl | output | 1 | 1 when `sym_data` is a control code |

## Verification
Address substitution and the end-of-body decision can fall in the same cycle: a `req_last` landing inside the source field must still get the station address on that byte, while also deciding between a normal close and a Void abort. The bench ends short bodies at index 2L-1 and at 2L to provoke this. It judges each case by comparing the complete symbol stream, including the trailing Void frame, against a model built from the requirements. A stall inside the address fields of a long frame with both transparency modes set tests abort and transparency together: the Void frame must ignore both modes.

// File: rtl/frm_tx_pkg.sv
package frm_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SD,
    ST_BODY,
    ST_VBODY,
    ST_FCS,
    ST_TR,
    ST_RR
  } tx_state_e;

  localparam logic [7:0] SYM_IDLE = 8'h00;
  localparam logic [7:0] SYM_JK   = 8'h01;
  localparam logic [7:0] SYM_TR   = 8'h02;
  localparam logic [7:0] SYM_RR   = 8'h03;

  localparam int FC_LONG_BIT = 6;

endpackage

// File: rtl/frm_tx_crc.sv
module frm_tx_crc #(
  parameter int CW = 32,
  parameter int SYM_W = 8,
  parameter logic [CW-1:0] POLY = 32'h04C11DB7,
  localparam int NB = CW / SYM_W,
  localparam int SEL_W = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             en,
  input  logic [SYM_W-1:0] din,
  input  logic [SEL_W-1:0] sel,
  output logic [SYM_W-1:0] fcs_byte
);

  logic [CW-1:0] crc_q;
  logic [CW-1:0] crc_nx;
  logic [CW-1:0] crc_inv;

  always_comb begin
    logic [CW-1:0] c;
    logic fb;
    c = crc_q;
    for (int b = SYM_W - 1; b >= 0; b--) begin
      fb = c[CW-1] ^ din[b];
      c  = {c[CW-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc_nx = c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= '1;
    else if (init) crc_q <= '1;
    else if (en)   crc_q <= crc_nx;
  end

  assign crc_inv  = ~crc_q;
  assign fcs_byte = SYM_W'(crc_inv >> (SYM_W * (NB - 1 - int'(sel))));

endmodule

// File: rtl/frm_tx_addr_sel.sv
module frm_tx_addr_sel #(
  parameter int SHORT_W = 16,
  parameter int LONG_W = 48,
  parameter int POS_W = 4,
  localparam int SHORT_B = SHORT_W / 8,
  localparam int LONG_B = LONG_W / 8
) (
  input  logic [POS_W-1:0]   pos,
  input  logic               is_long,
  input  logic [SHORT_W-1:0] stn_short,
  input  logic [LONG_W-1:0]  stn_long,
  output logic               in_sa,
  output logic               addr_done,
  output logic               addr_last,
  output logic [7:0]         own_byte
);

  always_comb begin
    int alen;
    int k;
    alen      = is_long ? LONG_B : SHORT_B;
    k         = int'(pos) - alen - 1;
    in_sa     = (int'(pos) >= alen + 1) && (int'(pos) <= 2 * alen);
    addr_done = int'(pos) >= 2 * alen;
    addr_last = int'(pos) == 2 * alen;
    own_byte  = 8'h00;
    if (in_sa) begin
      if (is_long) own_byte = 8'(stn_long >> (8 * (LONG_B - 1 - k)));
      else         own_byte = 8'(stn_short >> (8 * (SHORT_B - 1 - k)));
    end
  end

endmodule

// File: rtl/ring_frame_tx.sv
module ring_frame_tx
  import frm_tx_pkg::*;
#(
  parameter int PRE_MIN = 8,
  parameter int PRE_MAX = 40,
  parameter int SHORT_W = 16,
  parameter int LONG_W = 48,
  localparam int PRE_W = $clog2(PRE_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [7:0]         req_data,
  input  logic               req_last,
  output logic               req_ready,
  input  logic [PRE_W-1:0]   pre_len,
  input  logic               sa_pass,
  input  logic               fcs_pass,
  input  logic [SHORT_W-1:0] stn_short,
  input  logic [LONG_W-1:0]  stn_long,
  output logic [7:0]         sym_data,
  output logic               sym_ctrl
);

  localparam int LONG_B = LONG_W / 8;
  localparam int POS_W = $clog2(2 * LONG_B + 2);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  tx_state_e        state, st_n;
  logic [PRE_W-1:0] cnt, cnt_n, plen;
  logic [POS_W-1:0] pos, pos_n, pos_inc;
  logic             long_f, long_n, len_now;
  logic             void_pend, vp_n, void_act, va_n;
  logic [8:0]       sym_q, sym_n;
  logic             crc_init, crc_en;
  logic [7:0]       crc_din, fcs_byte;
  logic             in_sa, addr_done, addr_last;
  logic [7:0]       own_byte, body_byte, void_byte;

  // preamble clamp
  always_comb begin
    if (int'(pre_len) < PRE_MIN)      plen = PRE_W'(PRE_MIN);
    else if (int'(pre_len) > PRE_MAX) plen = PRE_W'(PRE_MAX);
    else                              plen = pre_len;
  end

  assign len_now = (state == ST_BODY && pos == '0) ? req_data[FC_LONG_BIT] : long_f;
  assign pos_inc = (pos == POS_MAX) ? pos : pos + 1'b1;

  frm_tx_addr_sel #(
    .SHORT_W(SHORT_W),
    .LONG_W (LONG_W),
    .POS_W  (POS_W)
  ) u_addr (
    .pos      (pos),
    .is_long  (len_now),
    .stn_short(stn_short),
    .stn_long (stn_long),
    .in_sa    (in_sa),
    .addr_done(addr_done),
    .addr_last(addr_last),
    .own_byte (own_byte)
  );

  assign body_byte = (in_sa && !sa_pass) ? own_byte : req_data;
  assign void_byte = (pos == '0) ? (8'(long_f) << FC_LONG_BIT) :
                     (in_sa ? own_byte : 8'h00);

  frm_tx_crc #(
    .CW   (32),
    .SYM_W(8)
  ) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (crc_init),
    .en      (crc_en),
    .din     (crc_din),
    .sel     (cnt[1:0]),
    .fcs_byte(fcs_byte)
  );

  assign req_ready = (state == ST_BODY);

  always_comb begin
    st_n     = state;
    cnt_n    = cnt;
    pos_n    = pos;
    long_n   = long_f;
    vp_n     = void_pend;
    va_n     = void_act;
    sym_n    = {1'b1, SYM_IDLE};
    crc_init = 1'b0;
    crc_en   = 1'b0;
    crc_din  = body_byte;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          st_n  = ST_PRE;
          cnt_n = '0;
        end
      end
      ST_PRE: begin
        if (cnt == plen - 1'b1) st_n = ST_SD;
        else                    cnt_n = cnt + 1'b1;
      end
      ST_SD: begin
        sym_n    = {1'b1, SYM_JK};
        pos_n    = '0;
        crc_init = 1'b1;
        if (void_act) begin
          st_n = ST_VBODY;
        end else begin
          st_n   = ST_BODY;
          long_n = 1'b0;
        end
      end
      ST_BODY: begin
        if (req_valid) begin
          sym_n  = {1'b0, body_byte};
          crc_en = 1'b1;
          pos_n  = pos_inc;
          if (pos == '0) long_n = req_data[FC_LONG_BIT];
          if (req_last) begin
            if (addr_done) begin
              st_n  = fcs_pass ? ST_TR : ST_FCS;
              cnt_n = '0;
            end else begin
              st_n = ST_TR;
              vp_n = 1'b1;
            end
          end
        end else begin
          sym_n = {1'b1, SYM_TR};
          st_n  = ST_RR;
          vp_n  = 1'b1;
        end
      end
      ST_VBODY: begin
        sym_n   = {1'b0, void_byte};
        crc_en  = 1'b1;
        crc_din = void_byte;
        pos_n   = pos_inc;
        if (addr_last) begin
          st_n  = ST_FCS;
          cnt_n = '0;
        end
      end
      ST_FCS: begin
        sym_n = {1'b0, fcs_byte};
        if (cnt[1:0] == 2'd3) st_n = ST_TR;
        else                  cnt_n = cnt + 1'b1;
      end
      ST_TR: begin
        sym_n = {1'b1, SYM_TR};
        st_n  = ST_RR;
      end
      ST_RR: begin
        sym_n = {1'b1, SYM_RR};
        if (void_pend) begin
          st_n  = ST_PRE;
          cnt_n = '0;
          vp_n  = 1'b0;
          va_n  = 1'b1;
        end else begin
          st_n = ST_IDLE;
          va_n = 1'b0;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      pos       <= '0;
      long_f    <= 1'b0;
      void_pend <= 1'b0;
      void_act  <= 1'b0;
      sym_q     <= {1'b1, SYM_IDLE};
    end else begin
      state     <= st_n;
      cnt       <= cnt_n;
      pos       <= pos_n;
      long_f    <= long_n;
      void_pend <= vp_n;
      void_act  <= va_n;
      sym_q     <= sym_n;
    end
  end

  assign sym_ctrl = sym_q[8];
  assign sym_data = sym_q[7:0];

  // ---------------- assertions ----------------
  logic [7:0] idle_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_run <= '0;
    else if (sym_ctrl && sym_data == SYM_IDLE)
      idle_run <= (idle_run == 8'hFF) ? idle_run : idle_run + 1'b1;
    else idle_run <= '0;
  end

  a_r2_preamble_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_ctrl && sym_data == SYM_JK) |-> (int'(idle_run) >= PRE_MIN));

  a_r3_data_after_jk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_ctrl && sym_data == SYM_JK) |=> (!sym_ctrl || sym_data == SYM_TR));

  a_r8_rr_follows_tr: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_ctrl && sym_data == SYM_TR) |=> (sym_ctrl && sym_data == SYM_RR));

  a_r10_stall_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> (sym_ctrl && sym_data == SYM_TR));

  a_r11_ready_drops_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_last) |=> !req_ready);

endmodule

// File: tb/ring_frame_tx_test.sv
module ring_frame_tx_test;
  localparam int CLK_P = 10;
  localparam logic [8:0] C_IDLE = 9'h100, C_JK = 9'h101, C_TR = 9'h102, C_RR = 9'h103;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_last = 1'b0, req_ready;
  logic [7:0]  req_data = 8'h00;
  logic [5:0]  pre_len = 6'd8;
  logic        sa_pass = 1'b0, fcs_pass = 1'b0;
  logic [15:0] stn_short = 16'hA1B2;
  logic [47:0] stn_long = 48'h0A1B2C3D4E5F;
  logic [7:0]  sym_data;
  logic        sym_ctrl;

  ring_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
    .req_last(req_last), .req_ready(req_ready), .pre_len(pre_len),
    .sa_pass(sa_pass), .fcs_pass(fcs_pass), .stn_short(stn_short),
    .stn_long(stn_long), .sym_data(sym_data), .sym_ctrl(sym_ctrl)
  );

  always #(CLK_P / 2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [8:0] lg [0:4095];
  int nlog = 0, rdy_cnt = 0, t_start = 0;
  logic [7:0] body [0:63];
  logic [8:0] expv [0:255];
  int ne = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (nlog < 4096) begin
        lg[nlog] = {sym_ctrl, sym_data};
        nlog++;
      end
      if (req_ready) rdy_cnt++;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[31] ^ b[i]) r = {r[30:0], 1'b0} ^ 32'h04C11DB7;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [7:0] own_b(input int L, input int k);
    if (L == 6) return stn_long[8*(5-k) +: 8];
    return stn_short[8*(1-k) +: 8];
  endfunction

  function automatic int clampp(input int p);
    if (p < 8) return 8;
    if (p > 40) return 40;
    return p;
  endfunction

  task automatic push(input logic [8:0] v);
    expv[ne] = v;
    ne++;
  endtask

  task automatic push_fcs(input logic [31:0] c);
    for (int i = 3; i >= 0; i--) push({1'b0, 8'(~c >> (8 * i))});
  endtask

  // expected stream from the start delimiter onward
  task automatic model(input int n, input bit stall, input int P);
    int L;
    logic [31:0] c;
    logic [7:0] b;
    bit aborted;
    ne = 0;
    c = 32'hFFFFFFFF;
    L = body[0][6] ? 6 : 2;
    push(C_JK);
    for (int j = 0; j < n; j++) begin
      b = body[j];
      if (!sa_pass && j >= L + 1 && j <= 2 * L) b = own_b(L, j - L - 1);
      push({1'b0, b});
      c = crc_upd(c, b);
    end
    aborted = stall || (n - 1 < 2 * L);
    if (!aborted && !fcs_pass) push_fcs(c);
    push(C_TR);
    push(C_RR);
    if (aborted) begin
      for (int i = 0; i < P; i++) push(C_IDLE);
      push(C_JK);
      c = 32'hFFFFFFFF;
      b = (L == 6) ? 8'h40 : 8'h00;
      push({1'b0, b});
      c = crc_upd(c, b);
      for (int i = 0; i < L; i++) begin
        push(9'h000);
        c = crc_upd(c, 8'h00);
      end
      for (int i = 0; i < L; i++) begin
        b = own_b(L, i);
        push({1'b0, b});
        c = crc_upd(c, b);
      end
      push_fcs(c);
      push(C_TR);
      push(C_RR);
    end
    push(C_IDLE);
    push(C_IDLE);
  endtask

  // called at a falling edge
  task automatic drive_body(input int n, input bit mark_last);
    int i;
    bit r;
    bit first;
    i = 0;
    first = 1'b1;
    req_valid = 1'b1;
    req_data = body[0];
    req_last = mark_last && (n == 1);
    while (i < n) begin
      #1;
      if (first) begin
        t_start = nlog;
        first = 1'b0;
      end
      r = req_ready;
      @(negedge clk);
      if (r) begin
        i++;
        if (i < n) begin
          req_data = body[i];
          req_last = mark_last && (i == n - 1);
        end else begin
          req_valid = 1'b0;
          req_last = 1'b0;
        end
      end
    end
  endtask

  task automatic run_case(input string tag, input int pl, input bit sp, input bit fp,
                          input int n, input bit mark_last);
    int P, rc0, base, bad_k;
    bit stall;
    stall = !mark_last;
    P = clampp(pl);
    @(negedge clk);
    pre_len = 6'(pl);
    sa_pass = sp;
    fcs_pass = fp;
    rc0 = rdy_cnt;
    drive_body(n, mark_last);
    repeat (P + 70) @(negedge clk);
    bad_k = -1;
    for (int k = 0; k <= P; k++) if (lg[t_start + k] !== C_IDLE && bad_k < 0) bad_k = k;
    chk({tag, " R2"}, "preamble idles", 32'(bad_k), 32'hFFFFFFFF);
    chk({tag, " R2"}, "delimiter position", 32'(lg[t_start + P + 1]), 32'(C_JK));
    model(n, stall, P);
    base = t_start + P + 1;
    bad_k = -1;
    for (int k = 0; k < ne; k++) if (lg[base + k] !== expv[k] && bad_k < 0) bad_k = k;
    if (bad_k < 0) chk(tag, "symbol stream", 32'd0, 32'd0);
    else chk(tag, $sformatf("symbol %0d", bad_k), 32'(lg[base + bad_k]), 32'(expv[bad_k]));
    chk({tag, " R11"}, "ready cycles", 32'(rdy_cnt - rc0), 32'(stall ? n + 1 : n));
  endtask

  task automatic t_reset;
    chk("R1", "reset ctrl", 32'(sym_ctrl), 32'd1);
    chk("R1", "reset data", 32'(sym_data), 32'd0);
    chk("R1", "reset ready", 32'(req_ready), 32'd0);
  endtask

  task automatic t_short_default;
    body[0] = 8'h10; body[1] = 8'h22; body[2] = 8'h33; body[3] = 8'hEE;
    body[4] = 8'hEE; body[5] = 8'h01; body[6] = 8'h02; body[7] = 8'h03;
    run_case("R3 R4 R5 R6 R8 short", 8, 1'b0, 1'b0, 8, 1'b1);
  endtask

  task automatic t_long_sa_pass;
    body[0] = 8'h50;
    for (int i = 1; i <= 6; i++) body[i] = 8'(8'h60 + i);
    for (int i = 7; i <= 12; i++) body[i] = 8'(8'h90 + i);
    body[13] = 8'hAB;
    run_case("R4 R5 R6 long-sa-pass", 20, 1'b1, 1'b0, 14, 1'b1);
    run_case("R5 long-own", 20, 1'b0, 1'b0, 14, 1'b1);
  endtask

  task automatic t_fcs_pass;
    body[0] = 8'h10; body[1] = 8'h44; body[2] = 8'h55; body[3] = 8'h00;
    body[4] = 8'h00; body[5] = 8'hDE; body[6] = 8'hAD; body[7] = 8'hBE; body[8] = 8'hEF;
    run_case("R7 fcs-pass", 12, 1'b0, 1'b1, 9, 1'b1);
  endtask

  task automatic t_clamp;
    body[0] = 8'h10; body[1] = 8'h01; body[2] = 8'h02; body[3] = 8'h03; body[4] = 8'h04;
    run_case("R2 R9 clamp-low boundary", 3, 1'b0, 1'b0, 5, 1'b1);
    run_case("R2 clamp-high", 63, 1'b0, 1'b0, 5, 1'b1);
  endtask

  task automatic t_early_last;
    body[0] = 8'h10; body[1] = 8'h01; body[2] = 8'h02; body[3] = 8'h77;
    run_case("R9 R12 early-last", 8, 1'b0, 1'b0, 4, 1'b1);
  endtask

  task automatic t_stall;
    body[0] = 8'h50;
    for (int i = 1; i < 7; i++) body[i] = 8'(8'hC0 + i);
    run_case("R10 stall long", 9, 1'b1, 1'b1, 7, 1'b0);
  endtask

  task automatic t_back_to_back;
    int r_i, j_i, base;
    body[0] = 8'h10; body[1] = 8'h11; body[2] = 8'h12; body[3] = 8'h13;
    body[4] = 8'h14; body[5] = 8'h15;
    @(negedge clk);
    pre_len = 6'd10;
    sa_pass = 1'b0;
    fcs_pass = 1'b0;
    drive_body(6, 1'b1);
    base = t_start;
    drive_body(6, 1'b1);
    repeat (60) @(negedge clk);
    r_i = -1;
    j_i = -1;
    for (int k = base; k < nlog; k++) if (r_i < 0 && lg[k] === C_RR) r_i = k;
    if (r_i >= 0)
      for (int k = r_i; k < nlog; k++) if (j_i < 0 && lg[k] === C_JK) j_i = k;
    chk("R12", "idles between frames", 32'(j_i - r_i - 1), 32'd11);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_short_default();
    t_long_sa_pass();
    t_fcs_pass();
    t_clamp();
    t_early_last();
    t_stall();
    t_back_to_back();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule